// File: doc/BRIEF.md
# Cache line burst fill controller

This block sits between a split instruction/data cache and the external bus. It decides whether a read needs the bus at all. When it does, it chooses between a wrapping burst that loads a whole four-long-word line and a single-entry cycle that fetches only the requested long word. It then streams each returned long word into the cache arrays. A long word is written only if caching is permitted for that word. Every write into the arrays also sets that long word's own valid bit.

The instruction and data sides each present a request, the tag-match result and the per-long-word valid bits of the indexed line. The control-register enable bits and a cache-inhibit input decide whether data may be cached. Only one fill runs at a time, and the data side wins a tie.

A bus error ends the fill at once. What happens next depends on the side and on the beat:

- A data-side error on the operand beat raises a bus-error exception.
- A data-side error on a later beat, which was only completing the line, silently invalidates the line.
- On the instruction side, an error only invalidates the line. If the operand word itself failed, the requester also gets a deferred fault marker, to be acted on only if that word is ever executed.

Top module: `line_fill_ctrl`

## Requirements
- R1: A read is served by a burst (`bus_burst`=1 with `bus_req`) only if its cache is enabled, that side's burst-enable bit is set, and either the tag misses or all valid bits of the indexed line are zero.
- R2: A burst starts at the long word addressed by the request (address bits [3:2]) and steps through the line modulo four. Each returned long word is written with `fill_lw` equal to the index shown on `bus_addr[3:2]` in that beat.
- R3: A read whose tag hits, while some long word of the line is valid but the requested one is not, uses a single-entry cycle. So does any read while that side's burst-enable bit is clear. Exactly one long word is fetched.
- R4: If `bus_burst_ok` is low on the first acknowledged beat of a burst, the fill ends after that one long word.
- R5: A read beat acknowledged with `bus_cinh` high writes nothing into the cache. Other beats of the same burst are still written.
- R6: With the side's cache disabled, a read is fetched in a single-entry cycle and returned on `op_data`, with no cache write.
- R7: A read whose tag hits and whose requested long word is valid is acknowledged with `op_hit` in the same cycle, with no bus request.
- R8: A data write makes one non-burst bus write (`bus_we`=1). The data cache word is written with the write data if and only if the data cache is enabled, `d_mmu_ok` is high, and either the tag hits or `dc_wr_alloc` is set. `bus_cinh` has no effect on this.
- R9: A data-side bus error on the first beat, which carries the operand, raises `exc_berr`, pulses `line_inval_d` for a read, and ends the fill.
- R10: A data-side bus error on a later beat pulses `line_inval_d` without `exc_berr`, and `bus_req` is low in the next cycle.
- R11: An instruction-side bus error pulses `line_inval_i` and never `exc_berr`. On the first beat it also pulses `i_fault`, which ends the request.
- R12: When both sides request in the same idle cycle, the data side is served first. The instruction side is served after the data fill ends.
- R13: After reset no bus request, cache write, acknowledge or error indication is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ic_en | input | 1 | Instruction cache enable |
| dc_en | input | 1 | Data cache enable |
| ic_burst_en | input | 1 | Instruction-side burst enable |
| dc_burst_en | input | 1 | Data-side burst enable |
| dc_wr_alloc | input | 1 | Write-allocate control for data writes |
| i_req | input | 1 | Instruction fetch request, held until acknowledged |
| i_addr | input | ADDR_W | Instruction fetch byte address |
| i_tag_hit | input | 1 | Tag match at indexed instruction line |
| i_line_valid | input | LINE_WORDS | Valid bits of indexed instruction line |
| d_req | input | 1 | Data request, held until acknowledged |
| d_we | input | 1 | Data request is a write |
| d_addr | input | ADDR_W | Data byte address |
| d_wdata | input | DATA_W | Data write value |
| d_tag_hit | input | 1 | Tag match at indexed data line |
| d_line_valid | input | LINE_WORDS | Valid bits of indexed data line |
| d_mmu_ok | input | 1 | Translation allows caching of the write |
| bus_req | output | 1 | Bus cycle request |
| bus_burst | output | 1 | Burst requested |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Current long-word address (byte offset on first beat) |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_burst_ok | input | 1 | Bus accepts burst, sampled on first beat |
| bus_rdata | input | DATA_W | Beat read data |
| bus_cinh | input | 1 | Cache inhibit for this beat |
| bus_err | input | 1 | Bus error for this beat |
| fill_we_i | output | 1 | Write one instruction cache long word and set its valid bit |
| fill_we_d | output | 1 | Write one data cache long word and set its valid bit |
| fill_lw | output | log2(LINE_WORDS) | Long word index within the line |
| fill_data | output | DATA_W | Long word to write |
| line_inval_i | output | 1 | Clear all valid bits of the instruction line |
| line_inval_d | output | 1 | Clear all valid bits of the data line |
| op_ack_i | output | 1 | Instruction operand delivered |
| op_ack_d | output | 1 | Data operand delivered or write done |
| op_hit | output | 1 | Acknowledge came from a cache hit |
| op_data | output | DATA_W | Operand data from the bus |
| exc_berr | output | 1 | Bus-error exception request |
| i_fault | output | 1 | Deferred fault marker for the fetched instruction word |

## Verification
The bench aims at the wrap order when the miss falls on the last long word of the line. A design with a non-wrapping counter would issue addresses beyond the line and fill the wrong slots. It also mixes cache-inhibit into a single beat of a burst. A design that latched inhibit for the whole line would drop good words, and one that ignored it would cache an uncacheable word. Bus errors on the first beat and on a later beat are applied to both sides. A design that does not separate operand beats from line-completion beats would either raise spurious exceptions or miss real ones. Finally, the bench covers a declined burst, the tag-hit-but-word-invalid case, an inhibited write, and a simultaneous request from both sides. Getting these wrong shows up as an extra bus beat, a burst where a single cycle belongs, a lost write update, or the instruction side winning the tie.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   typedef enum logic {
      SIDE_I = 1'b0,
      SIDE_D = 1'b1
   } side_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUS  = 1'b1
   } seq_st_e;

   // Decisions taken once when a request is accepted
   typedef struct packed {
      side_e side;
      logic  wr;     // data-side write cycle
      logic  burst;  // wrapping line burst requested
      logic  cen;    // cache enabled for this side
      logic  wupd;   // write updates the data cache
   } job_t;

endpackage

// File: rtl/lfc_arb.sv
module lfc_arb
   import lfc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORDS      = 4,
   parameter bit DATA_FIRST = 1'b1
) (
   input  logic              ic_en,
   input  logic              dc_en,
   input  logic              ic_burst_en,
   input  logic              dc_burst_en,
   input  logic              dc_wr_alloc,
   input  logic              i_req,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic              i_tag_hit,
   input  logic [WORDS-1:0]  i_line_valid,
   input  logic              d_req,
   input  logic              d_we,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic              d_tag_hit,
   input  logic [WORDS-1:0]  d_line_valid,
   input  logic              d_mmu_ok,
   output logic              sel_valid,
   output logic              sel_hit,
   output job_t              sel_job,
   output logic [ADDR_W-1:0] sel_addr
);

   localparam int LW_W = $clog2(WORDS);

   logic [LW_W-1:0] i_lw;
   logic [LW_W-1:0] d_lw;
   logic            i_hit;
   logic            d_hit;
   job_t            i_job;
   job_t            d_job;
   logic            take_d;

   assign i_lw = i_addr[2 +: LW_W];
   assign d_lw = d_addr[2 +: LW_W];

   // A line needs loading when its tag differs or none of its words is valid
   assign i_hit = ic_en && i_tag_hit && i_line_valid[i_lw];
   assign i_job = '{side:  SIDE_I,
                    wr:    1'b0,
                    burst: ic_en && ic_burst_en && (!i_tag_hit || (i_line_valid == '0)),
                    cen:   ic_en,
                    wupd:  1'b0};

   assign d_hit = !d_we && dc_en && d_tag_hit && d_line_valid[d_lw];
   assign d_job = '{side:  SIDE_D,
                    wr:    d_we,
                    burst: !d_we && dc_en && dc_burst_en &&
                           (!d_tag_hit || (d_line_valid == '0)),
                    cen:   dc_en,
                    wupd:  d_we && dc_en && d_mmu_ok && (d_tag_hit || dc_wr_alloc)};

   generate
      if (DATA_FIRST) begin : g_prio_d
         assign take_d = d_req;
      end else begin : g_prio_i
         assign take_d = d_req && !i_req;
      end
   endgenerate

   assign sel_valid = i_req || d_req;
   assign sel_hit   = take_d ? d_hit  : i_hit;
   assign sel_job   = take_d ? d_job  : i_job;
   assign sel_addr  = take_d ? d_addr : i_addr;

endmodule

// File: rtl/lfc_seq.sv
module lfc_seq
   import lfc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_valid,
   input  logic                     sel_hit,
   input  job_t                     sel_job,
   input  logic [ADDR_W-1:0]        sel_addr,
   input  logic [DATA_W-1:0]        wdata_in,
   output logic                     bus_req,
   output logic                     bus_burst,
   output logic                     bus_we,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [DATA_W-1:0]        bus_wdata,
   input  logic                     bus_ack,
   input  logic                     bus_burst_ok,
   input  logic [DATA_W-1:0]        bus_rdata,
   input  logic                     bus_cinh,
   input  logic                     bus_err,
   output logic                     fill_we_i,
   output logic                     fill_we_d,
   output logic [$clog2(WORDS)-1:0] fill_lw,
   output logic [DATA_W-1:0]        fill_data,
   output logic                     line_inval_i,
   output logic                     line_inval_d,
   output logic                     op_ack_i,
   output logic                     op_ack_d,
   output logic                     op_hit,
   output logic [DATA_W-1:0]        op_data,
   output logic                     exc_berr,
   output logic                     i_fault
);

   localparam int LW_W = $clog2(WORDS);

   seq_st_e           st;
   job_t              job;
   logic [ADDR_W-1:0] job_addr;
   logic [DATA_W-1:0] job_wdata;
   logic [LW_W-1:0]   cnt;
   logic [LW_W-1:0]   cur;
   logic              first;
   logic              last;
   logic              beat;
   logic              good;
   logic              bad;
   logic              wr_cache;
   logic              idle_hit;
   logic              is_d;

   // Wrap-around index: the line size is a power of two
   assign cur   = job_addr[2 +: LW_W] + cnt;
   assign first = (cnt == '0);
   assign is_d  = (job.side == SIDE_D);

   assign bus_req   = (st == ST_BUS);
   assign bus_burst = bus_req && job.burst;
   assign bus_we    = bus_req && job.wr;
   assign bus_addr  = {job_addr[ADDR_W-1:LW_W+2], cur, first ? job_addr[1:0] : 2'b00};
   assign bus_wdata = job_wdata;

   assign beat = bus_req && bus_ack;
   assign good = beat && !bus_err;
   assign bad  = beat && bus_err;
   assign last = !job.burst || (cnt == LW_W'(WORDS - 1)) || (first && !bus_burst_ok);

   // Writes ignore inhibit; reads cache a word only if its beat was cacheable
   assign wr_cache  = good && (job.wr ? job.wupd : (job.cen && !bus_cinh));
   assign fill_we_i = wr_cache && !is_d;
   assign fill_we_d = wr_cache && is_d;
   assign fill_lw   = cur;
   assign fill_data = job.wr ? job_wdata : bus_rdata;

   // Error outcome depends on the side and on whether the operand was in the beat
   assign line_inval_i = bad && !is_d;
   assign line_inval_d = bad && is_d && !job.wr;
   assign exc_berr     = bad && is_d && first;
   assign i_fault      = bad && !is_d && first;

   assign idle_hit = (st == ST_IDLE) && sel_valid && sel_hit;
   assign op_hit   = idle_hit;
   assign op_ack_i = (idle_hit && (sel_job.side == SIDE_I)) || (good && first && !is_d);
   assign op_ack_d = (idle_hit && (sel_job.side == SIDE_D)) || (good && first && is_d);
   assign op_data  = bus_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         job       <= '0;
         job_addr  <= '0;
         job_wdata <= '0;
         cnt       <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (sel_valid && !sel_hit) begin
                  st        <= ST_BUS;
                  job       <= sel_job;
                  job_addr  <= sel_addr;
                  job_wdata <= wdata_in;
                  cnt       <= '0;
               end
            end
            ST_BUS: begin
               if (beat) begin
                  if (bus_err || last) st <= ST_IDLE;
                  else                 cnt <= cnt + LW_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
   import lfc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter bit DATA_FIRST = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ic_en,
   input  logic                          dc_en,
   input  logic                          ic_burst_en,
   input  logic                          dc_burst_en,
   input  logic                          dc_wr_alloc,
   input  logic                          i_req,
   input  logic [ADDR_W-1:0]             i_addr,
   input  logic                          i_tag_hit,
   input  logic [LINE_WORDS-1:0]         i_line_valid,
   input  logic                          d_req,
   input  logic                          d_we,
   input  logic [ADDR_W-1:0]             d_addr,
   input  logic [DATA_W-1:0]             d_wdata,
   input  logic                          d_tag_hit,
   input  logic [LINE_WORDS-1:0]         d_line_valid,
   input  logic                          d_mmu_ok,
   output logic                          bus_req,
   output logic                          bus_burst,
   output logic                          bus_we,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic [DATA_W-1:0]             bus_wdata,
   input  logic                          bus_ack,
   input  logic                          bus_burst_ok,
   input  logic [DATA_W-1:0]             bus_rdata,
   input  logic                          bus_cinh,
   input  logic                          bus_err,
   output logic                          fill_we_i,
   output logic                          fill_we_d,
   output logic [$clog2(LINE_WORDS)-1:0] fill_lw,
   output logic [DATA_W-1:0]             fill_data,
   output logic                          line_inval_i,
   output logic                          line_inval_d,
   output logic                          op_ack_i,
   output logic                          op_ack_d,
   output logic                          op_hit,
   output logic [DATA_W-1:0]             op_data,
   output logic                          exc_berr,
   output logic                          i_fault
);

   localparam int LW_W = $clog2(LINE_WORDS);

   generate
      if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
         initial $fatal(1, "LINE_WORDS must be a power of two, at least 2");
      end
      if (ADDR_W <= LW_W + 2) begin : g_bad_addr
         initial $fatal(1, "ADDR_W too small for the line size");
      end
      if (DATA_W < 8) begin : g_bad_data
         initial $fatal(1, "DATA_W must be at least 8");
      end
   endgenerate

   logic              sel_valid;
   logic              sel_hit;
   job_t              sel_job;
   logic [ADDR_W-1:0] sel_addr;

   lfc_arb #(
      .ADDR_W     (ADDR_W),
      .WORDS      (LINE_WORDS),
      .DATA_FIRST (DATA_FIRST)
   ) u_arb (
      .ic_en        (ic_en),
      .dc_en        (dc_en),
      .ic_burst_en  (ic_burst_en),
      .dc_burst_en  (dc_burst_en),
      .dc_wr_alloc  (dc_wr_alloc),
      .i_req        (i_req),
      .i_addr       (i_addr),
      .i_tag_hit    (i_tag_hit),
      .i_line_valid (i_line_valid),
      .d_req        (d_req),
      .d_we         (d_we),
      .d_addr       (d_addr),
      .d_tag_hit    (d_tag_hit),
      .d_line_valid (d_line_valid),
      .d_mmu_ok     (d_mmu_ok),
      .sel_valid    (sel_valid),
      .sel_hit      (sel_hit),
      .sel_job      (sel_job),
      .sel_addr     (sel_addr)
   );

   lfc_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WORDS  (LINE_WORDS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_valid    (sel_valid),
      .sel_hit      (sel_hit),
      .sel_job      (sel_job),
      .sel_addr     (sel_addr),
      .wdata_in     (d_wdata),
      .bus_req      (bus_req),
      .bus_burst    (bus_burst),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_ack      (bus_ack),
      .bus_burst_ok (bus_burst_ok),
      .bus_rdata    (bus_rdata),
      .bus_cinh     (bus_cinh),
      .bus_err      (bus_err),
      .fill_we_i    (fill_we_i),
      .fill_we_d    (fill_we_d),
      .fill_lw      (fill_lw),
      .fill_data    (fill_data),
      .line_inval_i (line_inval_i),
      .line_inval_d (line_inval_d),
      .op_ack_i     (op_ack_i),
      .op_ack_d     (op_ack_d),
      .op_hit       (op_hit),
      .op_data      (op_data),
      .exc_berr     (exc_berr),
      .i_fault      (i_fault)
   );

endmodule

// File: rtl/lfc_chk.sv
module lfc_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_burst,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack,
   input logic              bus_cinh,
   input logic              bus_err,
   input logic              fill_we_i,
   input logic              fill_we_d,
   input logic              line_inval_i,
   input logic              exc_berr,
   input logic              i_fault,
   input logic              op_ack_i,
   input logic              op_ack_d,
   input logic              op_hit
);

   // R1: a burst is only ever a read request
   p_burst_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_burst |-> (bus_req && !bus_we));

   // R2: address is held while a beat is outstanding
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

   // R5: inhibited read beat never reaches the arrays
   p_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && bus_cinh && !bus_we) |-> !(fill_we_i || fill_we_d));

   // R5: array writes come only from a clean acknowledged beat
   p_fill_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we_i || fill_we_d) |-> (bus_ack && !bus_err));

   // R7: a hit acknowledge uses no bus cycle
   p_hit_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_hit |-> !bus_req);

   // R9: exception only on an erroring beat
   p_exc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_berr |-> (bus_req && bus_ack && bus_err));

   // R10: an error ends the bus activity
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && bus_err) |=> !bus_req);

   // R11: instruction-side errors never raise the exception
   p_ifetch_no_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (line_inval_i || i_fault) |-> !exc_berr);

   // R12: one fill at a time, one side acknowledged at a time
   p_one_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_ack_i, op_ack_d}));

endmodule

bind line_fill_ctrl lfc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_req      (bus_req),
   .bus_burst    (bus_burst),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_ack      (bus_ack),
   .bus_cinh     (bus_cinh),
   .bus_err      (bus_err),
   .fill_we_i    (fill_we_i),
   .fill_we_d    (fill_we_d),
   .line_inval_i (line_inval_i),
   .exc_berr     (exc_berr),
   .i_fault      (i_fault),
   .op_ack_i     (op_ack_i),
   .op_ack_d     (op_ack_d),
   .op_hit       (op_hit)
);

// File: tb/line_fill_ctrl_tb.sv
`timescale 1ns/1ps
module line_fill_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ic_en = 0, dc_en = 0, ic_burst_en = 0, dc_burst_en = 0, dc_wr_alloc = 0;
   logic        i_req = 0, i_tag_hit = 0;
   logic [31:0] i_addr = 0;
   logic [3:0]  i_line_valid = 0;
   logic        d_req = 0, d_we = 0, d_tag_hit = 0, d_mmu_ok = 0;
   logic [31:0] d_addr = 0, d_wdata = 0;
   logic [3:0]  d_line_valid = 0;
   logic        bus_req, bus_burst, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 0, bus_burst_ok = 1, bus_cinh = 0, bus_err = 0;
   logic [31:0] bus_rdata = 0;
   logic        fill_we_i, fill_we_d, line_inval_i, line_inval_d;
   logic [1:0]  fill_lw;
   logic [31:0] fill_data, op_data;
   logic        op_ack_i, op_ack_d, op_hit, exc_berr, i_fault;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   line_fill_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .ic_en(ic_en), .dc_en(dc_en), .ic_burst_en(ic_burst_en), .dc_burst_en(dc_burst_en),
      .dc_wr_alloc(dc_wr_alloc),
      .i_req(i_req), .i_addr(i_addr), .i_tag_hit(i_tag_hit), .i_line_valid(i_line_valid),
      .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_tag_hit(d_tag_hit),
      .d_line_valid(d_line_valid), .d_mmu_ok(d_mmu_ok),
      .bus_req(bus_req), .bus_burst(bus_burst), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_burst_ok(bus_burst_ok),
      .bus_rdata(bus_rdata), .bus_cinh(bus_cinh), .bus_err(bus_err),
      .fill_we_i(fill_we_i), .fill_we_d(fill_we_d), .fill_lw(fill_lw), .fill_data(fill_data),
      .line_inval_i(line_inval_i), .line_inval_d(line_inval_d),
      .op_ack_i(op_ack_i), .op_ack_d(op_ack_d), .op_hit(op_hit), .op_data(op_data),
      .exc_berr(exc_berr), .i_fault(i_fault)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // side 1 = data, 0 = instruction; errb 7 = no error; rq = requirement number
   typedef struct packed {
      logic       side;
      logic [1:0] lw;
      logic       th;
      logic [3:0] lv;
      logic       en;
      logic       ben;
      logic       bok;
      logic [3:0] cinh;
      logic [2:0] errb;
      logic       e_hit;
      logic       e_burst;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd1, 1'b0, 4'b1111, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd7, 1'b0, 1'b1, 4'd1},  // R1 data miss burst
      '{1'b0, 2'd3, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd7, 1'b0, 1'b1, 4'd2},  // R2 wrap from last word
      '{1'b1, 2'd1, 1'b1, 4'b0101, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd7, 1'b0, 1'b0, 4'd3},  // R3 tag hit, word invalid
      '{1'b1, 2'd1, 1'b1, 4'b0010, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd7, 1'b1, 1'b0, 4'd7},  // R7 read hit
      '{1'b0, 2'd2, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0000, 3'd7, 1'b0, 1'b0, 4'd3},  // R3 burst disabled
      '{1'b1, 2'd0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000, 3'd7, 1'b0, 1'b1, 4'd4},  // R4 burst declined
      '{1'b1, 2'd2, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0100, 3'd7, 1'b0, 1'b1, 4'd5},  // R5 inhibit on one beat
      '{1'b1, 2'd1, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 3'd7, 1'b0, 1'b0, 4'd6},  // R6 cache disabled
      '{1'b1, 2'd2, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd0, 1'b0, 1'b1, 4'd9},  // R9 operand error
      '{1'b1, 2'd0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd2, 1'b0, 1'b1, 4'd10}, // R10 line-completion error
      '{1'b0, 2'd1, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd0, 1'b0, 1'b1, 4'd11}, // R11 ifetch operand error
      '{1'b0, 2'd1, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 3'd1, 1'b0, 1'b1, 4'd11}, // R11 ifetch later error
      '{1'b0, 2'd0, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0001, 3'd7, 1'b0, 1'b0, 4'd5}   // R5 inhibited single
   };

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R13: reset state
      repeat (3) @(negedge clk);
      chk({bus_req, bus_burst, bus_we, fill_we_i, fill_we_d, op_ack_i, op_ack_d, op_hit,
           exc_berr, i_fault, line_inval_i, line_inval_d} == '0, "R13 reset idle",
          {bus_req, fill_we_i, fill_we_d, op_ack_i, op_ack_d, exc_berr}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         int nb;
         string tag;
         logic [11:0] got, exp;
         t = VEC[v];
         tag = $sformatf("R%0d vec%0d", t.rq, v);
         nb = t.e_hit ? 0 : (t.e_burst ? (t.bok ? 4 : 1) : 1);
         if (int'(t.errb) < nb) nb = int'(t.errb) + 1;
         if (t.side) begin
            dc_en = t.en; dc_burst_en = t.ben; d_req = 1; d_we = 0;
            d_addr = 32'h0000_1000 | (32'(t.lw) << 2); d_tag_hit = t.th; d_line_valid = t.lv;
         end else begin
            ic_en = t.en; ic_burst_en = t.ben; i_req = 1;
            i_addr = 32'h0000_2000 | (32'(t.lw) << 2); i_tag_hit = t.th; i_line_valid = t.lv;
         end
         bus_burst_ok = t.bok;
         #1;
         if (t.e_hit) begin
            chk({op_hit, op_ack_d, op_ack_i, bus_req} == {1'b1, t.side, !t.side, 1'b0}, tag,
                {op_hit, op_ack_d, op_ack_i, bus_req}, {1'b1, t.side, !t.side, 1'b0});
            d_req = 0; i_req = 0;
            @(negedge clk);
            chk(!bus_req, tag, bus_req, 0);
            continue;
         end
         @(negedge clk);
         for (int b = 0; b < nb; b++) begin
            logic err, we;
            logic [1:0] lwb;
            err = (b == int'(t.errb));
            lwb = t.lw + 2'(b);
            we  = !err && t.en && !t.cinh[b];
            bus_ack = 1; bus_cinh = t.cinh[b]; bus_err = err;
            bus_rdata = 32'hA5A5_0000 | 32'(b);
            #1;
            got = {bus_req, bus_burst, bus_addr[3:2], fill_we_i, fill_we_d, op_ack_i, op_ack_d,
                   exc_berr, line_inval_i, line_inval_d, i_fault};
            exp = {1'b1, t.e_burst, lwb, we && !t.side, we && t.side,
                   !err && b == 0 && !t.side, !err && b == 0 && t.side,
                   err && t.side && b == 0, err && !t.side, err && t.side, err && !t.side && b == 0};
            chk(got == exp, tag, got, exp);
            if (we) chk(fill_lw == lwb && fill_data == bus_rdata, tag, {fill_lw, fill_data}, {lwb, bus_rdata});
            if (b == 0 && !err) chk(op_data == 32'hA5A5_0000, tag, op_data, 32'hA5A5_0000);
            if (b == 0) begin d_req = 0; i_req = 0; end
            @(negedge clk);
         end
         bus_ack = 0; bus_cinh = 0; bus_err = 0;
         #1;
         chk(!bus_req, {tag, " fill ended"}, bus_req, 0);
         @(negedge clk);
      end

      // R8: writes, with and without allocation, inhibit asserted
      for (int w = 0; w < 3; w++) begin
         logic upd;
         dc_en = 1; d_mmu_ok = 1; d_req = 1; d_we = 1; d_addr = 32'h0000_3008;
         d_wdata = 32'hC0DE_0000 | 32'(w);
         d_tag_hit = (w == 2); dc_wr_alloc = (w == 1); dc_burst_en = 1;
         upd = (w != 0);
         @(negedge clk);
         chk({bus_req, bus_burst, bus_we, bus_addr[3:2]} == {3'b101, 2'd2}, "R8 write cycle",
             {bus_req, bus_burst, bus_we, bus_addr[3:2]}, {3'b101, 2'd2});
         chk(bus_wdata == d_wdata, "R8 write data", bus_wdata, d_wdata);
         bus_ack = 1; bus_cinh = 1;
         #1;
         chk({fill_we_d, op_ack_d, exc_berr} == {upd, 1'b1, 1'b0}, "R8 cache update ignores inhibit",
             {fill_we_d, op_ack_d, exc_berr}, {upd, 1'b1, 1'b0});
         if (upd) chk(fill_data == d_wdata && fill_lw == 2'd2, "R8 update value",
                      fill_data, d_wdata);
         d_req = 0;
         @(negedge clk);
         bus_ack = 0; bus_cinh = 0;
      end
      d_we = 0; dc_wr_alloc = 0;

      // R12: both sides miss in the same idle cycle
      dc_en = 1; ic_en = 1; dc_burst_en = 0; ic_burst_en = 0;
      d_tag_hit = 0; i_tag_hit = 0;
      d_addr = 32'h0000_1004; i_addr = 32'h0000_200C;
      @(negedge clk);
      d_req = 1; i_req = 1;
      @(negedge clk);
      chk(bus_req && bus_addr == 32'h0000_1004, "R12 data first", bus_addr, 32'h0000_1004);
      bus_ack = 1; bus_rdata = 32'h1111_2222;
      #1;
      chk({op_ack_d, op_ack_i} == 2'b10, "R12 data acknowledged alone", {op_ack_d, op_ack_i}, 2'b10);
      d_req = 0;
      @(negedge clk);
      bus_ack = 0;
      @(negedge clk);
      chk(bus_req && bus_addr == 32'h0000_200C, "R12 instruction next", bus_addr, 32'h0000_200C);
      bus_ack = 1;
      #1;
      chk({op_ack_d, op_ack_i, fill_we_i} == 3'b011, "R12 instruction served",
          {op_ack_d, op_ack_i, fill_we_i}, 3'b011);
      i_req = 0;
      @(negedge clk);
      bus_ack = 0;
      @(negedge clk);

      finish_run();
   end

endmodule